// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This unit gathers single-cycle event pulses from the transmit, receive, link and bus-error logic. It holds them in a cause register and drives one level-sensitive interrupt line. The line is high while any cause bit is set together with its mask bit. Software reads the cause register to learn what happened, and that read also empties the register. The mask is changed through two write addresses: one sets the mask bits written as 1, the other clears them.

Completion events are not posted the moment they arrive. Receive-done on queue 0 and transmit-done each pass through a holdoff timer, so that a burst of completions yields one interrupt rather than many. The receive timer has an enable flag and a count. The transmit timer has only a count, which comes out of reset at 128 cycles. A count of zero, or a cleared receive enable, posts the event at once.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset the cause register reads 0, the mask reads 0, `irq_o` is 0, the receive holdoff register reads 0 and the transmit holdoff register reads 128.
- R2: Cause bit positions are fixed. Bit 1 is transmit queue empty, bit 2 is link change, bit 3 is receive symbol error, bits 4 and 5 are receive queue 0 and queue 1 empty, bit 8 is receive-done queue 1 and bit 9 is bus error. A pulse on `evt_i` at any of these positions sets that cause bit at the next clock edge. Bit 6 is unused and always reads 0.
- R3: A read at address 0 returns the cause register and clears it at the same clock edge.
- R4: An event that arrives in the same cycle as a clearing read is not returned by that read. It is set in the cause register and returned by the next read.
- R5: A write to address 1 sets every mask bit whose data bit is 1 and leaves the others unchanged. Reads at address 1 or 2 return the mask.
- R6: A write to address 2 clears every mask bit whose data bit is 1 and leaves the others unchanged.
- R7: `irq_o` is 1 exactly when some cause bit and the same mask bit are both 1.
- R8: Receive-done queue 0 (`evt_i` bit 7, cause bit 7) is delayed by the receive holdoff. When the enable bit (bit 31 of address 3) is set and the count N (bits 15:0) is non-zero, cause bit 7 is set N clock edges after the edge that captured the event. Otherwise it is set at that same edge.
- R9: Transmit-done (`evt_i` bit 0, cause bit 0) is delayed by the count N in bits 15:0 of address 4 in the same way. N = 0 posts it at once.
- R10: Once a holdoff countdown has started, further events on the same source neither restart nor extend it. The countdown posts exactly once.
- R11: Address 3 reads back bit 31 as the enable and bits 15:0 as the count. Address 4 reads back the count in bits 15:0. Other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| evt_i | input | 10 | Event pulses, one per cause bit position |
| bus_en_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address (0 cause, 1 mask set, 2 mask clear, 3 receive holdoff, 4 transmit holdoff) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two situations are the hardest to reach from the ports. The first is an event colliding with a clearing read. The bench drives an event pulse in exactly the cycle of the read strobe, then checks that the first read omits the event and the second read returns it. The second is a repeated completion during a holdoff countdown. The bench pulses the source again two cycles into the countdown. It reads the cause register the cycle before and the cycle after the original expiry, then reads it once more a few cycles later to confirm that no second posting occurred. The default 128-cycle transmit holdoff is checked with the same before-and-after read pair.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int CAUSE_W = 10;
  localparam int DATA_W  = 32;

  // cause bit positions (decoded by software)
  localparam int B_TX_DONE   = 0;
  localparam int B_RX0_DONE  = 7;

  localparam logic [CAUSE_W-1:0] VALID_BITS  = 10'h3BF;
  localparam logic [CAUSE_W-1:0] DIRECT_BITS = 10'h33E;

  typedef enum logic [2:0] {
    A_CAUSE  = 3'd0,
    A_MSET   = 3'd1,
    A_MCLR   = 3'd2,
    A_RXHOLD = 3'd3,
    A_TXHOLD = 3'd4
  } reg_addr_e;

  function automatic logic [CAUSE_W-1:0] cause_next(
      input logic [CAUSE_W-1:0] cur, input logic clr, input logic [CAUSE_W-1:0] post);
    cause_next = (clr ? '0 : cur) | (post & VALID_BITS);
  endfunction

  function automatic logic [CAUSE_W-1:0] mask_next(
      input logic [CAUSE_W-1:0] cur, input logic [CAUSE_W-1:0] set_bits,
      input logic [CAUSE_W-1:0] clr_bits);
    mask_next = ((cur | set_bits) & ~clr_bits) & VALID_BITS;
  endfunction
endpackage

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig_i,
  input  logic [W-1:0] delay_i,
  output logic         post_o,
  output logic         busy_o,
  output logic [W-1:0] cnt_o
);
  logic         busy_q;
  logic [W-1:0] cnt_q;
  logic         start, expire, bypass;

  assign start  = trig_i && !busy_q && (delay_i != '0);
  assign bypass = trig_i && !busy_q && (delay_i == '0);
  assign expire = busy_q && (cnt_q == W'(1));
  assign post_o = bypass || expire;
  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= delay_i;
    end else if (expire) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_cause_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [CAUSE_W-1:0] post_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q;
  assign cause_o = cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_next(cause_q, clr_i, post_i);
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_cause_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en_i,
  input  logic               clr_en_i,
  input  logic [CAUSE_W-1:0] bits_i,
  output logic [CAUSE_W-1:0] mask_o
);
  logic [CAUSE_W-1:0] mask_q;
  assign mask_o = mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next(mask_q, set_en_i ? bits_i : '0,
                                    clr_en_i ? bits_i : '0);
  end
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
#(
  parameter int HOLD_W      = 16,
  parameter int TX_HOLD_RST = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] evt_i,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [2:0]         bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  // named internal events (observed by the bound checker)
  logic               rd_cause, wr_set, wr_clr, wr_rxh, wr_txh;
  logic [CAUSE_W-1:0] wdata_c, set_vec, cause_q, mask_q;
  logic               rx_post, tx_post, rx_busy, tx_busy;
  logic [HOLD_W-1:0]  rx_cnt, tx_cnt, rx_delay;

  logic               rx_hold_en_q;
  logic [HOLD_W-1:0]  rx_hold_cnt_q, tx_hold_cnt_q;

  assign rd_cause = bus_en_i && !bus_we_i && (bus_addr_i == A_CAUSE);
  assign wr_set   = bus_en_i &&  bus_we_i && (bus_addr_i == A_MSET);
  assign wr_clr   = bus_en_i &&  bus_we_i && (bus_addr_i == A_MCLR);
  assign wr_rxh   = bus_en_i &&  bus_we_i && (bus_addr_i == A_RXHOLD);
  assign wr_txh   = bus_en_i &&  bus_we_i && (bus_addr_i == A_TXHOLD);
  assign wdata_c  = bus_wdata_i[CAUSE_W-1:0];
  assign rx_delay = rx_hold_en_q ? rx_hold_cnt_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hold_en_q  <= 1'b0;
      rx_hold_cnt_q <= '0;
      tx_hold_cnt_q <= HOLD_W'(TX_HOLD_RST);
    end else begin
      if (wr_rxh) begin
        rx_hold_en_q  <= bus_wdata_i[DATA_W-1];
        rx_hold_cnt_q <= bus_wdata_i[HOLD_W-1:0];
      end
      if (wr_txh) tx_hold_cnt_q <= bus_wdata_i[HOLD_W-1:0];
    end
  end

  irq_holdoff_timer #(.W(HOLD_W)) rx_tmr_i (
    .clk(clk), .rst_n(rst_n), .trig_i(evt_i[B_RX0_DONE]), .delay_i(rx_delay),
    .post_o(rx_post), .busy_o(rx_busy), .cnt_o(rx_cnt));

  irq_holdoff_timer #(.W(HOLD_W)) tx_tmr_i (
    .clk(clk), .rst_n(rst_n), .trig_i(evt_i[B_TX_DONE]), .delay_i(tx_hold_cnt_q),
    .post_o(tx_post), .busy_o(tx_busy), .cnt_o(tx_cnt));

  always_comb begin
    set_vec             = evt_i & DIRECT_BITS;
    set_vec[B_RX0_DONE] = rx_post;
    set_vec[B_TX_DONE]  = tx_post;
  end

  irq_cause_reg cause_i (
    .clk(clk), .rst_n(rst_n), .clr_i(rd_cause), .post_i(set_vec), .cause_o(cause_q));

  irq_mask_reg mask_i (
    .clk(clk), .rst_n(rst_n), .set_en_i(wr_set), .clr_en_i(wr_clr),
    .bits_i(wdata_c), .mask_o(mask_q));

  assign irq_o = |(cause_q & mask_q);

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CAUSE:        bus_rdata_o[CAUSE_W-1:0] = cause_q;
      A_MSET, A_MCLR: bus_rdata_o[CAUSE_W-1:0] = mask_q;
      A_RXHOLD: begin
        bus_rdata_o[DATA_W-1]   = rx_hold_en_q;
        bus_rdata_o[HOLD_W-1:0] = rx_hold_cnt_q;
      end
      A_TXHOLD:       bus_rdata_o[HOLD_W-1:0] = tx_hold_cnt_q;
      default:        bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
  import irq_cause_pkg::*;
#(
  parameter int HOLD_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CAUSE_W-1:0] evt_i,
  input logic [CAUSE_W-1:0] cause_q,
  input logic [CAUSE_W-1:0] mask_q,
  input logic [CAUSE_W-1:0] set_vec,
  input logic [CAUSE_W-1:0] wdata_c,
  input logic               rd_cause,
  input logic               wr_set,
  input logic               wr_clr,
  input logic               irq_o,
  input logic               rx_busy,
  input logic [HOLD_W-1:0]  rx_cnt,
  input logic               tx_busy,
  input logic [HOLD_W-1:0]  tx_cnt
);
  assert_direct_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & DIRECT_BITS)) |=>
      ((cause_q & $past(evt_i & DIRECT_BITS)) == $past(evt_i & DIRECT_BITS)));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && set_vec == '0) |=> (cause_q == '0));

  assert_read_keeps_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && set_vec != '0) |=> (cause_q == $past(set_vec)));

  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask_q & $past(wdata_c)) == ($past(wdata_c) & VALID_BITS)));

  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_q & $past(wdata_c)) == '0));

  assert_no_mask_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  assert_rx_countdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && rx_cnt != HOLD_W'(1)) |=> (rx_busy && rx_cnt == $past(rx_cnt) - HOLD_W'(1)));

  assert_tx_countdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_cnt != HOLD_W'(1)) |=> (tx_busy && tx_cnt == $past(tx_cnt) - HOLD_W'(1)));
endmodule

bind irq_cause_unit irq_cause_chk #(.HOLD_W(HOLD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cause_q(cause_q), .mask_q(mask_q),
  .set_vec(set_vec), .wdata_c(wdata_c), .rd_cause(rd_cause), .wr_set(wr_set),
  .wr_clr(wr_clr), .irq_o(irq_o), .rx_busy(rx_busy), .rx_cnt(rx_cnt),
  .tx_busy(tx_busy), .tx_cnt(tx_cnt));

// File: tb/irq_cause_unit_tb_top.sv
`timescale 1ns/1ps
module irq_cause_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  irq_cause_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit en, input bit we, input logic [2:0] a,
                       input logic [31:0] d, input logic [9:0] e);
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; evt = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 3'd0, 32'h0, 10'h0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    drive(1, 1, a, d, 10'h0);
  endtask

  task automatic pulse(input logic [9:0] e);
    drive(0, 0, 3'd0, 32'h0, e);
  endtask

  // read with optional simultaneous event; expected value goes to the scoreboard
  task automatic rd_evt(input logic [2:0] a, input logic [9:0] e,
                        input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    drive(1, 0, a, 32'h0, e);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_evt(a, 10'h0, exp, tag);
  endtask

  task automatic irq_chk(input bit exp, input string tag);
    drive(0, 0, 3'd0, 32'h0, 10'h0);
    #2;
    chk(irq == exp, tag, {31'h0, irq}, {31'h0, exp});
  endtask

  // monitor: pops expected read data as the design returns it
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_en && !bus_we) begin
        if (sb_q.size() == 0) chk(1'b0, "scoreboard underflow", bus_rdata, 32'h0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          chk(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    irq_chk(1'b0, "R1 irq after reset");
    rd(3'd0, 32'h0, "R1 cause after reset");
    rd(3'd1, 32'h0, "R1 mask after reset");
    rd(3'd3, 32'h0, "R1 rx holdoff after reset");
    rd(3'd4, 32'd128, "R1 tx holdoff after reset");
    // R2 direct events incl. unused bit 6; R3 clear on read
    pulse(10'h37E);
    rd(3'd0, 32'h33E, "R2 direct cause bits");
    rd(3'd0, 32'h0, "R3 cause cleared by read");
    // R5 / R6 mask set and clear
    wr(3'd1, 32'h00C);
    rd(3'd1, 32'h00C, "R5 mask set");
    wr(3'd1, 32'h010);
    rd(3'd2, 32'h01C, "R5 zero bits keep mask");
    wr(3'd2, 32'h004);
    rd(3'd1, 32'h018, "R6 mask clear");
    wr(3'd2, 32'h000);
    rd(3'd1, 32'h018, "R6 zero bits keep mask");
    // R7 irq = OR(cause & mask), mask now 0x018
    pulse(10'h004);
    irq_chk(1'b0, "R7 masked cause gives no irq");
    pulse(10'h008);
    irq_chk(1'b1, "R7 enabled cause raises irq");
    rd(3'd0, 32'h00C, "R3 read returns both causes");
    irq_chk(1'b0, "R7 irq drops after clearing read");
    // R4 event during clearing read
    pulse(10'h004);
    rd_evt(3'd0, 10'h200, 32'h004, "R4 read excludes same-cycle event");
    rd(3'd0, 32'h200, "R4 same-cycle event kept");
    // R8 receive holdoff, R11 readback
    wr(3'd3, 32'h8000_0005);
    rd(3'd3, 32'h8000_0005, "R11 rx holdoff readback");
    pulse(10'h080);
    idle(4);
    rd(3'd0, 32'h0, "R8 rx done held off before expiry");
    rd(3'd0, 32'h080, "R8 rx done posted after 5 cycles");
    wr(3'd3, 32'h0000_0005);
    pulse(10'h080);
    rd(3'd0, 32'h080, "R8 enable off posts at once");
    wr(3'd3, 32'h8000_0000);
    pulse(10'h080);
    rd(3'd0, 32'h080, "R8 zero count posts at once");
    // R10 repeat event during countdown
    wr(3'd3, 32'h8000_0005);
    pulse(10'h080);
    idle(1);
    pulse(10'h080);
    idle(2);
    rd(3'd0, 32'h0, "R10 not posted early");
    rd(3'd0, 32'h080, "R10 posted at original time");
    idle(8);
    rd(3'd0, 32'h0, "R10 no second posting");
    // R9 transmit holdoff, default 128
    pulse(10'h001);
    idle(127);
    rd(3'd0, 32'h0, "R9 tx done held 128 before expiry");
    rd(3'd0, 32'h001, "R9 tx done posted after 128");
    wr(3'd4, 32'd3);
    rd(3'd4, 32'd3, "R11 tx holdoff readback");
    pulse(10'h001);
    idle(2);
    rd(3'd0, 32'h0, "R9 tx short holdoff before expiry");
    rd(3'd0, 32'h001, "R9 tx short holdoff posted");
    wr(3'd4, 32'd0);
    pulse(10'h001);
    rd(3'd0, 32'h001, "R9 zero count posts at once");
    idle(2);
    finish_run();
  end
endmodule